// File: doc/BRIEF.md
# Page Copy Engine with Inline Match Filter and Masked Summation

This block relocates one memory page from a source page address to a destination page address. It reads the page line by line into a 16-slot staging buffer and then writes those same lines to the destination. The data never passes through processor registers. While each line arrives, a combinational stage works on its 32-bit elements. Depending on the command mode, the engine does one of three things: nothing beyond the copy, an equality test of every element against a query word, or a sum of only those elements whose bit is set in a caller-supplied mask.

A command is accepted on a valid/ready handshake. The engine keeps `cmd_ready` low from the cycle after acceptance until the cycle after its completion pulse, so a second command sent while it is busy is ignored. Memory traffic uses three valid/ready channels: read request, read response and write. A transfer happens on every edge where valid and ready are both high. A sender that raises valid keeps it high, with address and data unchanged, until ready is seen. The engine holds `rd_rsp_ready` high for the whole read phase. Read responses must come back in request order, one per request, with any latency of at least one cycle. Both page addresses must have their low 12 bits at zero.

A filter run produces a 1024-bit qualification vector and a hit count. A masked-sum run produces a 64-bit sum and the number of summed elements. All results are valid when `done` pulses and stay unchanged until the next command is accepted.

Top module: `pme_engine`

## Requirements
- R1: After reset: `cmd_ready` is 1; `done`, `rd_req_valid`, `wr_valid`, `res_mask`, `res_count` and `res_sum` are 0.
- R2: A command is taken on an edge with `cmd_valid` and `cmd_ready` both high. From the next cycle, `cmd_ready` stays 0 until the cycle after `done`. Commands presented in that interval change nothing.
- R3: The engine issues exactly 16 read requests, at addresses `src + 256*k` for k = 0..15 in ascending order. Each request's valid and address hold until accepted. No more responses are accepted than requests issued.
- R4: No write is issued before the 16th response is accepted. Exactly 16 writes then go to `dst + 256*k` in ascending order, each carrying line k of the source page unchanged. Valid, address and data hold until accepted.
- R5: `done` is high for exactly one cycle: the cycle after the last write handshake. Results are valid then and stay stable, with `cmd_ready` high again, in the following cycle.
- R6: Mode encoding: `cmd_mode` 0 = copy, 1 = filter, 2 = masked sum, 3 = behaves exactly as copy.
- R7: In filter mode, `res_mask[i]` is 1 exactly when element i equals `cmd_query`. Element i lives in line i/64, bits `[(i%64)*32 +: 32]`, so element 0 is the lowest address. `res_sum` is 0.
- R8: In filter mode, `res_count` equals the number of ones in `res_mask`, from 0 up to 1024.
- R9: In masked-sum mode, `res_sum` is the 64-bit unsigned sum of every element i with `cmd_mask[i]` set, and `res_count` is the number of ones in `cmd_mask`. `res_mask` is 0.
- R10: In copy mode, `res_mask`, `res_count` and `res_sum` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_mode | input | 2 | 0 copy, 1 filter, 2 masked sum, 3 copy |
| cmd_src | input | 32 | Page-aligned source byte address |
| cmd_dst | input | 32 | Page-aligned destination byte address |
| cmd_query | input | 32 | Value compared in filter mode |
| cmd_mask | input | 1024 | Element selection for masked sum |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts read request |
| rd_req_addr | output | 32 | Line byte address to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine accepts read data |
| rd_rsp_data | input | 2048 | One line of read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Memory accepts write |
| wr_addr | output | 32 | Line byte address to write |
| wr_data | output | 2048 | One line of write data |
| done | output | 1 | One-cycle completion pulse |
| res_mask | output | 1024 | Qualification vector from filter mode |
| res_count | output | 11 | Hit count or summed-element count |
| res_sum | output | 64 | Masked sum |

## Verification
Filter runs use pages whose match density ranges from none through sparse and dense to every element. A directed page matches only at element 0 and element 1023; this separates a correct element order from a reversed or shifted lane mapping. Masked-sum runs use an empty mask, a full mask over all-ones elements (which exercises the widest sum and the full count of 1024), a mask taken from an earlier filter result, and random masks. These runs tell correct mask pairing apart from summing every element. Copy and the spare mode code are run while commands keep arriving during busy periods, and random ready and response delays on all three memory channels test whether data order and handshake holding survive back-pressure.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [1:0] {
    MODE_COPY   = 2'd0,
    MODE_FILTER = 2'd1,
    MODE_AGG    = 2'd2,
    MODE_SPARE  = 2'd3
  } pme_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } pme_state_e;
endpackage

// File: rtl/pme_line_buf.sv
module pme_line_buf #(
  parameter int LINES  = 16,
  parameter int LINE_W = 2048,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] slot [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_line;
  end

  assign rd_line = slot[rd_idx];
endmodule

// File: rtl/pme_line_calc.sv
module pme_line_calc #(
  parameter int LINE_W = 2048,
  parameter int ELEM_W = 32,
  parameter int SUM_W  = 64,
  localparam int EPL   = LINE_W / ELEM_W,
  localparam int PC_W  = $clog2(EPL) + 1
) (
  input  logic [LINE_W-1:0] line,
  input  logic [ELEM_W-1:0] query,
  input  logic              filter_en,
  input  logic              agg_en,
  input  logic [EPL-1:0]    sel_in,
  output logic [EPL-1:0]    hit,
  output logic [PC_W-1:0]   hit_cnt,
  output logic [SUM_W-1:0]  hit_sum
);
  logic [EPL-1:0] eq;

  for (genvar e = 0; e < EPL; e++) begin : g_lane
    assign eq[e]  = (line[e*ELEM_W +: ELEM_W] == query);
    assign hit[e] = filter_en ? eq[e] : (agg_en & sel_in[e]);
  end

  always_comb begin
    hit_cnt = '0;
    hit_sum = '0;
    for (int e = 0; e < EPL; e++) begin
      hit_cnt = hit_cnt + PC_W'(hit[e]);
      if (agg_en && sel_in[e])
        hit_sum = hit_sum + SUM_W'(line[e*ELEM_W +: ELEM_W]);
    end
  end
endmodule

// File: rtl/pme_ctrl.sv
module pme_ctrl
  import pme_pkg::*;
#(
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int CW    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  output logic             start,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [IDX_W-1:0] rd_req_idx,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             rsp_fire,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [IDX_W-1:0] wr_idx,
  output logic             done
);
  pme_state_e state;
  logic [CW-1:0] rq_cnt, rs_cnt, wr_cnt;
  logic req_fire, wr_fire;

  assign cmd_ready    = (state == ST_IDLE);
  assign start        = cmd_valid && cmd_ready;
  assign rd_req_valid = (state == ST_READ) && (rq_cnt < CW'(LINES));
  assign rd_rsp_ready = (state == ST_READ);
  assign wr_valid     = (state == ST_WRITE);
  assign done         = (state == ST_DONE);
  assign req_fire     = rd_req_valid && rd_req_ready;
  assign rsp_fire     = rd_rsp_valid && rd_rsp_ready;
  assign wr_fire      = wr_valid && wr_ready;
  assign rd_req_idx   = rq_cnt[IDX_W-1:0];
  assign rsp_idx      = rs_cnt[IDX_W-1:0];
  assign wr_idx       = wr_cnt[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rq_cnt <= '0;
      rs_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          state  <= ST_READ;
          rq_cnt <= '0;
          rs_cnt <= '0;
          wr_cnt <= '0;
        end
        ST_READ: begin
          if (req_fire) rq_cnt <= rq_cnt + 1'b1;
          if (rsp_fire) begin
            rs_cnt <= rs_cnt + 1'b1;
            if (rs_cnt == CW'(LINES - 1)) state <= ST_WRITE;
          end
        end
        ST_WRITE: if (wr_fire) begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == CW'(LINES - 1)) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  rsp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_cnt <= rq_cnt);

  // R4
  wr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (rs_cnt == CW'(LINES)));
endmodule

// File: rtl/pme_engine.sv
module pme_engine
  import pme_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LINE_W = 2048,
  parameter int ELEM_W = 32,
  parameter int LINES  = 16,
  parameter int SUM_W  = 64,
  localparam int EPL   = LINE_W / ELEM_W,
  localparam int PELEM = EPL * LINES,
  localparam int CNT_W = $clog2(PELEM) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_mode,
  input  logic [AW-1:0]     cmd_src,
  input  logic [AW-1:0]     cmd_dst,
  input  logic [ELEM_W-1:0] cmd_query,
  input  logic [PELEM-1:0]  cmd_mask,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [AW-1:0]     rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [LINE_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [LINE_W-1:0] wr_data,
  output logic              done,
  output logic [PELEM-1:0]  res_mask,
  output logic [CNT_W-1:0]  res_count,
  output logic [SUM_W-1:0]  res_sum
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = $clog2(LINE_W / 8);
  localparam int PC_W  = $clog2(EPL) + 1;

  pme_mode_e         mode_q;
  logic [AW-1:0]     src_q, dst_q;
  logic [ELEM_W-1:0] query_q;
  logic [PELEM-1:0]  sel_q;

  logic             start, rsp_fire;
  logic [IDX_W-1:0] rq_idx, rs_idx, wr_idx;
  logic             filter_en, agg_en;
  logic [EPL-1:0]   hit;
  logic [PC_W-1:0]  hit_cnt;
  logic [SUM_W-1:0] hit_sum;

  pme_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_idx(rq_idx),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rsp_idx(rs_idx), .rsp_fire(rsp_fire),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
    .done(done)
  );

  pme_line_buf #(.LINES(LINES), .LINE_W(LINE_W)) u_buf (
    .clk(clk), .wr_en(rsp_fire), .wr_idx(rs_idx), .wr_line(rd_rsp_data),
    .rd_idx(wr_idx), .rd_line(wr_data)
  );

  assign filter_en = (mode_q == MODE_FILTER);
  assign agg_en    = (mode_q == MODE_AGG);

  pme_line_calc #(.LINE_W(LINE_W), .ELEM_W(ELEM_W), .SUM_W(SUM_W)) u_calc (
    .line(rd_rsp_data), .query(query_q),
    .filter_en(filter_en), .agg_en(agg_en),
    .sel_in(sel_q[rs_idx*EPL +: EPL]),
    .hit(hit), .hit_cnt(hit_cnt), .hit_sum(hit_sum)
  );

  assign rd_req_addr = src_q + (AW'(rq_idx) << OFS_W);
  assign wr_addr     = dst_q + (AW'(wr_idx) << OFS_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_COPY;
      src_q     <= '0;
      dst_q     <= '0;
      query_q   <= '0;
      sel_q     <= '0;
      res_mask  <= '0;
      res_count <= '0;
      res_sum   <= '0;
    end else if (start) begin
      mode_q    <= pme_mode_e'(cmd_mode);
      src_q     <= cmd_src;
      dst_q     <= cmd_dst;
      query_q   <= cmd_query;
      sel_q     <= cmd_mask;
      res_mask  <= '0;
      res_count <= '0;
      res_sum   <= '0;
    end else if (rsp_fire) begin
      if (filter_en) res_mask[rs_idx*EPL +: EPL] <= hit;
      res_count <= res_count + CNT_W'(hit_cnt);
      res_sum   <= res_sum + hit_sum;
    end
  end

  // R2
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  // R5
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_count <= CNT_W'(PELEM));
endmodule

// File: tb/pme_engine_test.sv
`timescale 1ns/1ps
module pme_engine_test;
  localparam int LW = 2048;
  localparam int NL = 16;
  localparam int EPL = 64;
  localparam int PE = 1024;
  localparam int NPG = 4;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_mode = 0;
  logic [31:0] cmd_src = 0, cmd_dst = 0, cmd_query = 0;
  logic [PE-1:0] cmd_mask = '0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0, rd_rsp_ready;
  logic [31:0] rd_req_addr, wr_addr;
  logic [LW-1:0] rd_rsp_data = '0, wr_data;
  logic wr_valid, wr_ready = 0, done;
  logic [PE-1:0] res_mask;
  logic [10:0] res_count;
  logic [63:0] res_sum;

  pme_engine uut (.*);

  logic [LW-1:0] tbm [NPG*NL];
  int checks = 0, errors = 0;
  int n_req, n_rsp, n_wr, req_bad, wr_bad, wr_early;
  logic [31:0] cur_src, cur_dst;
  int q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PE-1:0] act, input logic [PE-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: all decisions taken at the falling edge
  initial begin
    bit rq_f, rs_f, wr_f;
    logic [31:0] rq_a, w_a;
    logic [LW-1:0] w_d;
    rq_f = 0; rs_f = 0; wr_f = 0; rq_a = 0; w_a = 0; w_d = '0;
    forever begin
      @(negedge clk);
      if (rq_f) begin
        if (rq_a != cur_src + 32'(n_req * 256)) req_bad++;
        q.push_back(int'(rq_a[13:8]));
        n_req++;
      end
      if (rs_f) begin
        void'(q.pop_front());
        n_rsp++;
      end
      if (wr_f) begin
        if (n_rsp < NL) wr_early++;
        if (w_a != cur_dst + 32'(n_wr * 256) || w_d != tbm[int'(cur_src[13:8]) + n_wr]) wr_bad++;
        n_wr++;
      end
      rd_req_ready = ($urandom % 4) != 0;
      wr_ready = ($urandom % 4) != 0;
      rd_rsp_valid = (q.size() > 0) && (($urandom % 3) != 0);
      rd_rsp_data = (q.size() > 0) ? tbm[q[0]] : '0;
      rq_f = rd_req_valid && rd_req_ready;
      rq_a = rd_req_addr;
      rs_f = rd_rsp_valid && rd_rsp_ready;
      wr_f = wr_valid && wr_ready;
      w_a = wr_addr;
      w_d = wr_data;
    end
  end

  function automatic logic [31:0] elem(int p, int e);
    return tbm[p*NL + e/EPL][(e%EPL)*32 +: 32];
  endfunction

  task automatic set_elem(int p, int e, logic [31:0] v);
    tbm[p*NL + e/EPL][(e%EPL)*32 +: 32] = v;
  endtask

  task automatic fill(int p, logic [31:0] qv, int pct);
    for (int e = 0; e < PE; e++) begin
      logic [31:0] v = $urandom;
      if (v == qv) v = v ^ 32'h1;
      if (int'($urandom % 100) < pct) v = qv;
      set_elem(p, e, v);
    end
  endtask

  function automatic logic [PE-1:0] ref_mask(int p, logic [31:0] qv);
    logic [PE-1:0] m = '0;
    for (int e = 0; e < PE; e++) m[e] = (elem(p, e) == qv);
    return m;
  endfunction

  function automatic logic [63:0] ref_sum(int p, logic [PE-1:0] m);
    logic [63:0] s = 0;
    for (int e = 0; e < PE; e++) if (m[e]) s += 64'(elem(p, e));
    return s;
  endfunction

  task automatic run(input logic [1:0] mode, input int sp, input int dp,
                     input logic [31:0] qv, input logic [PE-1:0] m, input bit poke);
    logic [PE-1:0] e_mask;
    logic [10:0] e_cnt;
    logic [63:0] e_sum;
    int wait_c;
    e_mask = '0; e_cnt = 0; e_sum = 0;
    if (mode == 2'd1) begin
      e_mask = ref_mask(sp, qv);
      e_cnt = 11'($countones(e_mask));
    end else if (mode == 2'd2) begin
      e_sum = ref_sum(sp, m);
      e_cnt = 11'($countones(m));
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    n_req = 0; n_rsp = 0; n_wr = 0; req_bad = 0; wr_bad = 0; wr_early = 0;
    cur_src = 32'(sp * 4096); cur_dst = 32'(dp * 4096);
    cmd_valid = 1; cmd_mode = mode; cmd_src = cur_src; cmd_dst = cur_dst;
    cmd_query = qv; cmd_mask = m;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R2", "ready after accept", PE'(cmd_ready), '0);
    if (poke) begin
      cmd_valid = 1; cmd_mode = 2'd1; cmd_query = ~qv; cmd_mask = ~m;
      cmd_src = 32'h3000; cmd_dst = 32'h2000;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!cmd_ready, "R2", "ready while busy", PE'(cmd_ready), '0);
      end
      cmd_valid = 0;
    end
    wait_c = 0;
    while (!done && wait_c < 5000) begin @(negedge clk); wait_c++; end
    chk(done, "R5", "done seen", PE'(done), PE'(1));
    chk(req_bad == 0 && n_req == NL, "R3", "read requests", PE'(n_req), PE'(NL));
    chk(wr_bad == 0 && n_wr == NL, "R4", "written lines", PE'(n_wr - wr_bad), PE'(NL));
    chk(wr_early == 0, "R4", "early writes", PE'(wr_early), '0);
    case (mode)
      2'd1: begin
        chk(res_mask == e_mask, "R7", "filter mask", res_mask, e_mask);
        chk(res_count == e_cnt, "R8", "filter count", PE'(res_count), PE'(e_cnt));
        chk(res_sum == 0, "R7", "filter sum", PE'(res_sum), '0);
      end
      2'd2: begin
        chk(res_sum == e_sum, "R9", "masked sum", PE'(res_sum), PE'(e_sum));
        chk(res_count == e_cnt, "R9", "sum count", PE'(res_count), PE'(e_cnt));
        chk(res_mask == 0, "R9", "sum mask", res_mask, '0);
      end
      default:
        chk(res_mask == 0 && res_count == 0 && res_sum == 0,
            (mode == 2'd3) ? "R6" : "R10", "copy results",
            PE'(res_count) | PE'(res_sum) | res_mask, '0);
    endcase
    @(negedge clk);
    chk(!done && cmd_ready, "R5", "done width", PE'({done, cmd_ready}), PE'(2'b01));
    chk(res_mask == e_mask && res_count == e_cnt && res_sum == e_sum, "R5",
        "results held", PE'(res_count), PE'(e_cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PE-1:0] fm;
    void'($urandom(32'd20240611));
    for (int p = 0; p < NPG * NL; p++) tbm[p] = '0;
    cur_src = 0; cur_dst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !done && !rd_req_valid && !wr_valid, "R1", "reset controls",
        PE'({cmd_ready, done, rd_req_valid, wr_valid}), PE'(4'b1000));
    chk(res_mask == 0 && res_count == 0 && res_sum == 0, "R1", "reset results",
        PE'(res_count), '0);
    rst_n = 1;

    fill(0, 32'd5, 30);
    run(2'd1, 0, 1, 32'd5, '0, 1);
    fm = res_mask;
    fill(2, 32'd9, 0);
    run(2'd2, 2, 3, 32'd0, fm, 0);          // R9 mask from filter
    run(2'd0, 2, 1, 32'd0, {32{32'hA5A5_5A5A}}, 1);  // R10 copy
    run(2'd3, 0, 3, 32'd5, '1, 1);          // R6 spare code
    fill(1, 32'd7, 0);
    run(2'd1, 1, 2, 32'd7, '0, 0);          // R8 zero hits
    set_elem(1, 0, 32'd7);
    set_elem(1, PE - 1, 32'd7);
    run(2'd1, 1, 0, 32'd7, '0, 0);          // R7 first and last element
    fill(3, 32'hDEAD_BEEF, 100);
    run(2'd1, 3, 0, 32'hDEAD_BEEF, '0, 0);  // R8 full page
    fill(3, 32'hFFFF_FFFF, 100);
    run(2'd2, 3, 1, 32'd0, '1, 0);          // R9 widest sum
    run(2'd2, 3, 1, 32'd0, '0, 1);          // R9 empty mask
    for (int i = 0; i < 6; i++) begin
      logic [PE-1:0] rm;
      int sp;
      for (int w = 0; w < PE / 32; w++) rm[w*32 +: 32] = $urandom;
      sp = int'($urandom % NPG);
      fill(sp, 32'(i + 100), int'($urandom % 60));
      run(2'(i % 3), sp, (sp + 1) % NPG, 32'(i + 100), rm, i[0]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule